// File: doc/BRIEF.md
# Eight-Channel External Interrupt Controller

This block watches eight external request pins and turns activity on them into a single prioritised interrupt request for a CPU. Each pin passes through a synchroniser. A per-channel two-bit sense setting then selects what counts as an event on that pin: a low level, any change, a falling edge or a rising edge. An edge event sets a per-channel pending flag whether or not that channel is enabled. A level-sensed channel keeps no flag. Its request follows the synchronised pin for as long as the pin is low.

The CPU sees the block through four byte-wide registers on a simple write-strobe bus: the enable mask, the pending flags, and two bytes of sense settings. Reads are combinational from the current address. A request leaves the block only when the channel's enable bit and the global enable input are both high. The lowest-numbered requesting channel wins, and its index is presented with the request. When the CPU takes the vector it pulses the acknowledge input, which clears the winning channel's flag. Software can also clear flags by writing ones to them. The block samples the pad value of each pin, so a pin the chip drives itself still raises events.

Top module: `xint_ctrl`

## Requirements
- R1: After reset all four registers read 0x00 and `irq_o` is low.
- R2: Address 2 holds the sense settings of channels 0 to 3 and address 3 those of channels 4 to 7. Channel i uses bits [2i+1:2i] of the 16-bit value {addr3, addr2}. The codes are 00 = low level, 01 = any change, 10 = falling edge and 11 = rising edge. Both bytes read back what was written.
- R3: A pin change that matches an edge-type sense setting sets that channel's flag (address 1, bit i) on the third rising clock edge after the pin changes. This happens regardless of the enable bit and of `gie_i`.
- R4: In a write to address 1, a one in bit i clears flag i and a zero leaves it unchanged. If a new event for the channel is detected in the same cycle, the flag ends up set.
- R5: A channel in low-level mode always reads flag 0. While enabled, it requests for as long as its synchronised pin is low, which is from the second rising edge after the pin falls.
- R6: `irq_o` is high exactly when `gie_i` is high and at least one channel has its enable bit set together with either a set flag or an active low level.
- R7: While `irq_o` is high, `irq_id_o` gives the lowest-numbered channel that is requesting.
- R8: `ack_i` high while `irq_o` is high clears the flag of channel `irq_id_o` at that clock edge, unless a new event sets it in the same cycle. `ack_i` has no effect while `irq_o` is low.
- R9: Address 0 is the enable mask, with bit i enabling channel i. It reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | External request pins (pad values) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Vector taken for the presented channel |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 mask, 1 flags, 2/3 sense) |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 3 | Index of the winning channel |

## Verification
Each result has its own due cycle. Flags react to a pin edge on the third rising clock edge, level requests appear after the second, and register writes and acknowledge clears are visible one edge later. `irq_o` and `irq_id_o` follow the registered state in the same cycle, combinationally. The bench's reference model keeps a three-entry queue of pin samples and advances its flags and registers once per rising edge. All port values are compared against it at the following falling edge, so every response is checked in exactly the cycle it is due. Directed phases place an edge in the same cycle as a clearing write, and an acknowledge in the same cycle as a competing request. A long random phase mixes writes, pin activity and acknowledges.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int XI_NCH  = 8;
  localparam int XI_IDW  = $clog2(XI_NCH);
  localparam int XI_SNW  = 2;
  localparam int XI_ADW  = 2;

  localparam logic [XI_ADW-1:0] ADR_MASK   = 2'd0;
  localparam logic [XI_ADW-1:0] ADR_FLAG   = 2'd1;
  localparam logic [XI_ADW-1:0] ADR_SNS_LO = 2'd2;
  localparam logic [XI_ADW-1:0] ADR_SNS_HI = 2'd3;

  typedef enum logic [XI_SNW-1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] cur_o,
  output logic [NCH-1:0] prev_o
);
  // STAGES synchroniser flops plus one delayed copy for edge comparison
  logic [STAGES:0][NCH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = pin_i;
    for (int k = 1; k <= STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/xint_chan.sv
module xint_chan
  import xint_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e mode_i,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   clr_wr_i,
  input  logic   clr_ack_i,
  input  logic   en_i,
  output logic   flag_o,
  output logic   edge_o,
  output logic   req_o
);
  logic hit, flag_q, flag_d, flag_ce;

  always_comb begin
    unique case (mode_i)
      SNS_ANY:  hit = cur_i ^ prev_i;
      SNS_FALL: hit = prev_i & ~cur_i;
      SNS_RISE: hit = ~prev_i & cur_i;
      default:  hit = 1'b0;
    endcase
  end

  // set wins over both clear sources; level mode forces the flag low
  always_comb begin
    if (mode_i == SNS_LOW) flag_d = 1'b0;
    else                   flag_d = hit | (flag_q & ~(clr_wr_i | clr_ack_i));
    flag_ce = hit | clr_wr_i | clr_ack_i | (mode_i == SNS_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign edge_o = hit;
  assign req_o  = en_i & ((mode_i == SNS_LOW) ? ~cur_i : flag_q);
endmodule

// File: rtl/xint_prio.sv
module xint_prio #(
  parameter int NCH = 8,
  parameter int IDW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [IDW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDW'(k);
    end
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XI_NCH-1:0] pin_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic              bus_wr_i,
  input  logic [XI_ADW-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o,
  output logic [XI_IDW-1:0] irq_id_o
);
  localparam int SNSW = XI_NCH * XI_SNW;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // register file: enable mask and sense settings
  logic [XI_NCH-1:0] en_q, en_d;
  logic [SNSW-1:0]   sns_q, sns_d;
  logic              en_ce, sns_ce;
  logic [XI_NCH-1:0] flag_q, edge_vec, req_vec, clr_wr, clr_ack;
  logic [XI_NCH-1:0] cur_v, prev_v;

  always_comb begin
    en_d   = en_q;
    sns_d  = sns_q;
    en_ce  = bus_wr_i && (bus_addr_i == ADR_MASK);
    sns_ce = bus_wr_i && ((bus_addr_i == ADR_SNS_LO) || (bus_addr_i == ADR_SNS_HI));
    if (en_ce) en_d = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == ADR_SNS_LO) sns_d[7:0]  = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == ADR_SNS_HI) sns_d[15:8] = bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= '0;
      sns_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (sns_ce) sns_q <= sns_d;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      ADR_MASK:   bus_rdata_o = en_q;
      ADR_FLAG:   bus_rdata_o = flag_q;
      ADR_SNS_LO: bus_rdata_o = sns_q[7:0];
      default:    bus_rdata_o = sns_q[15:8];
    endcase
  end

  xint_sync #(.NCH(XI_NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pin_i  (pin_i),
    .cur_o  (cur_v),
    .prev_o (prev_v)
  );

  // one-hot clear from acknowledge of the presented channel
  always_comb begin
    for (int i = 0; i < XI_NCH; i++) begin
      clr_wr[i]  = bus_wr_i && (bus_addr_i == ADR_FLAG) && bus_wdata_i[i];
      clr_ack[i] = ack_i && irq_o && (irq_id_o == XI_IDW'(i));
    end
  end

  for (genvar g = 0; g < XI_NCH; g++) begin : g_ch
    xint_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .mode_i    (sense_e'(sns_q[XI_SNW*g +: XI_SNW])),
      .cur_i     (cur_v[g]),
      .prev_i    (prev_v[g]),
      .clr_wr_i  (clr_wr[g]),
      .clr_ack_i (clr_ack[g]),
      .en_i      (en_q[g]),
      .flag_o    (flag_q[g]),
      .edge_o    (edge_vec[g]),
      .req_o     (req_vec[g])
    );
  end

  xint_prio #(.NCH(XI_NCH), .IDW(XI_IDW)) u_prio (
    .req_i (req_vec & {XI_NCH{gie_i}}),
    .any_o (irq_o),
    .idx_o (irq_id_o)
  );
endmodule

// File: rtl/xint_chk.sv
module xint_chk
  import xint_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              gie_i,
  input logic              ack_i,
  input logic              bus_wr_i,
  input logic [XI_ADW-1:0] bus_addr_i,
  input logic [7:0]        bus_wdata_i,
  input logic              irq_o,
  input logic [XI_IDW-1:0] irq_id_o,
  input logic [XI_NCH-1:0] flag_q,
  input logic [XI_NCH-1:0] edge_vec,
  input logic [XI_NCH-1:0] req_vec,
  input logic [2*XI_NCH-1:0] sns_q
);
  logic [XI_NCH-1:0] lvl_mask;
  logic [XI_NCH-1:0] below_id;

  always_comb begin
    for (int i = 0; i < XI_NCH; i++) begin
      lvl_mask[i] = (sns_q[2*i +: 2] == SNS_LOW);
      below_id[i] = (XI_IDW'(i) < irq_id_o);
    end
  end

  // R6
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  // R7
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (req_vec[irq_id_o] && ((req_vec & below_id) == '0)));

  // R3
  edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edge_vec != '0) |=> ((flag_q & $past(edge_vec)) == $past(edge_vec)));

  // R4
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADR_FLAG) |=>
      ((flag_q & $past(bus_wdata_i & ~edge_vec)) == '0));

  // R5
  level_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lvl_mask != '0) |=> ((flag_q & $past(lvl_mask)) == '0));

  // R8
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_i && irq_o) |=>
      (!flag_q[$past(irq_id_o)] || $past(edge_vec[irq_id_o])));
endmodule

bind xint_ctrl xint_chk u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .irq_id_o    (irq_id_o),
  .flag_q      (flag_q),
  .edge_vec    (edge_vec),
  .req_vec     (req_vec),
  .sns_q       (sns_q)
);

// File: tb/sim_xint_ctrl.sv
module sim_xint_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] pin_i;
  logic       gie_i, ack_i, bus_wr_i;
  logic [1:0] bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       irq_o;
  logic [2:0] irq_id_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  xint_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;
  string cur_tag = "R3";

  // reference model state
  logic [7:0]  m_en, m_flg;
  logic [15:0] m_sns;
  logic [7:0]  hist[$];

  function automatic int mode_of(int ch);
    return int'(m_sns[2*ch +: 2]);
  endfunction

  function automatic logic [7:0] m_req();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_en[i] && gie_i && ((mode_of(i) == 0) ? !hist[1][i] : m_flg[i]);
    return r;
  endfunction

  function automatic int m_id(logic [7:0] r);
    for (int i = 0; i < 8; i++) if (r[i]) return i;
    return 0;
  endfunction

  task automatic model_edge();
    logic [7:0] r, nf;
    int id;
    r  = m_req();
    id = m_id(r);
    for (int i = 0; i < 8; i++) begin
      bit h1, h2, ev, clr;
      h1 = hist[1][i];
      h2 = hist[2][i];
      case (mode_of(i))
        1: ev = (h1 != h2);
        2: ev = h2 && !h1;
        3: ev = !h2 && h1;
        default: ev = 0;
      endcase
      clr = (bus_wr_i && bus_addr_i == 2'd1 && bus_wdata_i[i]) ||
            (ack_i && (r != 0) && id == i);
      if (mode_of(i) == 0) nf[i] = 0;
      else nf[i] = ev || (m_flg[i] && !clr);
    end
    m_flg = nf;
    if (bus_wr_i && bus_addr_i == 2'd0) m_en = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == 2'd2) m_sns[7:0] = bus_wdata_i;
    if (bus_wr_i && bus_addr_i == 2'd3) m_sns[15:8] = bus_wdata_i;
    hist.push_front(pin_i);
    void'(hist.pop_back());
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] r, exp_rd;
    string tag;
    r = m_req();
    check("R6", "irq_o", irq_o, (r != 0));
    if (r != 0) check("R7", "irq_id_o", irq_id_o, m_id(r));
    case (bus_addr_i)
      2'd0: begin exp_rd = m_en;        tag = "R9"; end
      2'd1: begin exp_rd = m_flg;       tag = cur_tag; end
      2'd2: begin exp_rd = m_sns[7:0];  tag = "R2"; end
      default: begin exp_rd = m_sns[15:8]; tag = "R2"; end
    endcase
    check(tag, "bus_rdata_o", bus_rdata_o, exp_rd);
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      if (model_on) model_edge();
      @(negedge clk_i);
      if (model_on) compare();
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    step();
    bus_wr_i = 0; bus_addr_i = 2'd1; bus_wdata_i = 0;
  endtask

  initial begin
    rst_ni = 0; pin_i = 0; gie_i = 0; ack_i = 0;
    bus_wr_i = 0; bus_addr_i = 2'd1; bus_wdata_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr_i = 2'(a);
      #1;
      check("R1", "reset register", bus_rdata_o, 0);
    end
    check("R1", "reset irq_o", irq_o, 0);
    bus_addr_i = 2'd1;
    m_en = 0; m_flg = 0; m_sns = 0;
    hist = {8'h00, 8'h00, 8'h00};
    model_on = 1;

    // configuration: R9 mask, R2 sense (ch0-3 rise, ch4 fall, ch5 any, ch6 rise, ch7 level)
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'h36);
    bus_addr_i = 2'd2; step(); bus_addr_i = 2'd3; step(); bus_addr_i = 2'd0; step();
    bus_addr_i = 2'd1;

    // R3: edges with global enable off
    cur_tag = "R3";
    pin_i = 8'h0F; step(5);
    pin_i = 8'hF0; step(5);
    pin_i = 8'h00; step(5);

    // R4: write-one-to-clear, zero writes, set beats clear
    cur_tag = "R4";
    wr_reg(2'd1, 8'h05); step(2);
    wr_reg(2'd1, 8'h00); step(2);
    wr_reg(2'd1, 8'hFF); step(2);
    pin_i = 8'h02; step(2);
    wr_reg(2'd1, 8'h02); step(3);

    // R8: acknowledge drains flags lowest first; level channel 7 stays requesting
    cur_tag = "R8";
    pin_i = 8'h6D; step(4);
    gie_i = 1; step(2);
    ack_i = 1; step(8);
    ack_i = 0; step(2);

    // R5: level channel follows the pin, never flags
    cur_tag = "R5";
    pin_i[7] = 1; step(4);
    pin_i[7] = 0; step(4);
    wr_reg(2'd0, 8'h7F); step(2);
    gie_i = 0; step(2);

    // mixed random traffic
    cur_tag = "R3";
    for (int c = 0; c < 1500; c++) begin
      if ($urandom_range(0, 3) == 0) pin_i = 8'($urandom);
      gie_i = ($urandom_range(0, 3) != 0);
      ack_i = ($urandom_range(0, 2) == 0);
      bus_wr_i = ($urandom_range(0, 7) == 0);
      bus_addr_i = 2'($urandom);
      bus_wdata_i = 8'($urandom);
      step();
    end
    bus_wr_i = 0; ack_i = 0;
    step(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule